// File: doc/BRIEF.md
# Serial 1-1-0 Pattern Detector on JK Storage

This block watches a single serial input bit that is sampled on every rising clock edge. It raises its output for one full clock period once the three most recent samples were one, one and then zero. The output is a Moore output, so it depends only on the stored state and never directly on the live input.

The state is held in two JK flip-flops. The next state is not assigned directly. Instead, combinational excitation logic works out the J and K inputs of each flip-flop from the present state and the input. A small reusable JK flip-flop module provides the storage. An asynchronous active-high reset returns the machine to its idle state.

Top module: `seq110_detector`

## Requirements
- R1: While `rst` is high, the state is idle (00) and `hit` is 0. Raising `rst` forces `hit` low at once, without waiting for a clock edge.
- R2: After a rising edge, `hit` is 1 exactly when the samples of `din` taken at the three most recent rising edges since reset were 1, 1, 0, oldest first.
- R3: `hit` depends only on the stored state. A change of `din` between clock edges leaves `hit` unchanged.
- R4: The state code is held as two bits, high then low: idle=00, one-seen=01, two-seen=10, match=11. The transitions on `din`=0/1 are: idle→idle/one-seen, one-seen→idle/two-seen, two-seen→match/two-seen, match→idle/one-seen.
- R5: The JK storage element, on a rising edge with J,K = 00 holds, 01 clears to 0, 10 sets to 1, and 11 inverts its value.
- R6: Any run of two or more consecutive 1s keeps `hit` low. The first 0 after such a run raises `hit`.
- R7: `hit` is never high for two consecutive cycles. Overlapping input such as 1,1,0,1,1,0 raises it once for each complete pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high, returns to idle |
| din | input | 1 | Serial data bit |
| hit | output | 1 | High for one period after 1,1,0 was sampled |

## Verification
The bench aims at the long run of 1s. A machine that mishandles two-seen on a 1 would fall back to idle and miss the pattern 1110. It also drives back-to-back overlapping patterns. A match state that returned to idle on a 1 would miss the second 110 of 110110. Toggling the input mid-cycle while the match state is held exposes any Mealy-style leak of `din` into `hit`. Asserting reset between edges shows whether the reset is really asynchronous. The JK element is driven on its own through all four J/K codes, because a swapped set/clear or a missing toggle shows up there before the excitation terms hide it.

// File: rtl/seq110_pkg.sv
package seq110_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_HIT  = 2'b11
  } st_e;

  // Characteristic function of a JK storage bit.
  function automatic logic jk_apply(input logic q, input logic j, input logic k);
    logic r;
    unique case ({j, k})
      2'b00:   r = q;
      2'b01:   r = 1'b0;
      2'b10:   r = 1'b1;
      default: r = ~q;
    endcase
    return r;
  endfunction

  // Minimised J terms, index = state bit.
  function automatic logic [STATE_W-1:0] j_terms(input logic [STATE_W-1:0] s, input logic a);
    return {s[0] & a, s[1] ^ a};
  endfunction

  // Minimised K terms, index = state bit.
  function automatic logic [STATE_W-1:0] k_terms(input logic [STATE_W-1:0] s, input logic a);
    return {s[0], ~(s[1] & a)};
  endfunction

  // Transition table used by the checker as an independent reference.
  function automatic st_e ref_next(input st_e s, input logic a);
    st_e n;
    unique case (s)
      ST_IDLE: n = a ? ST_ONE : ST_IDLE;
      ST_ONE:  n = a ? ST_TWO : ST_IDLE;
      ST_TWO:  n = a ? ST_TWO : ST_HIT;
      default: n = a ? ST_ONE : ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/seq110_jk_ff.sv
module seq110_jk_ff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  import seq110_pkg::*;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= RST_VAL;
    else     q <= jk_apply(q, j, k);
  end
endmodule

// File: rtl/seq110_excite.sv
module seq110_excite
  import seq110_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic               din,
  output logic [STATE_W-1:0] j_vec,
  output logic [STATE_W-1:0] k_vec
);
  always_comb begin
    j_vec = j_terms(state, din);
    k_vec = k_terms(state, din);
  end
endmodule

// File: rtl/seq110_decode.sv
module seq110_decode
  import seq110_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  output logic               hit
);
  always_comb hit = (state == ST_HIT);
endmodule

// File: rtl/seq110_detector.sv
module seq110_detector
  import seq110_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] j_vec;
  logic [STATE_W-1:0] k_vec;

  seq110_excite exc_i (
    .state (state_q),
    .din   (din),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar b = 0; b < STATE_W; b++) begin : g_bit
    seq110_jk_ff #(.RST_VAL(1'b0)) ff_i (
      .clk (clk),
      .rst (rst),
      .j   (j_vec[b]),
      .k   (k_vec[b]),
      .q   (state_q[b])
    );
  end

  seq110_decode dec_i (
    .state (state_q),
    .hit   (hit)
  );
endmodule

// File: rtl/seq110_chk.sv
module seq110_chk
  import seq110_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               din,
  input logic               hit,
  input logic [STATE_W-1:0] state_q,
  input logic [STATE_W-1:0] j_vec,
  input logic [STATE_W-1:0] k_vec
);
  // R1: reset holds idle
  always @(posedge clk) begin
    if (rst) begin
      p_reset_idle_r1: assert (state_q == ST_IDLE && !hit);
    end
  end

  // R2: a high output is preceded by samples 1,1,0
  p_hit_after_pattern_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(din, 1) == 1'b0 && $past(din, 2) == 1'b1 && $past(din, 3) == 1'b1));

  // R4: state follows the reference transition table
  p_transition_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> state_q == ref_next(st_e'($past(state_q)), $past(din)));

  // R5: each storage bit obeys its J/K inputs
  for (genvar b = 0; b < STATE_W; b++) begin : g_jk
    p_jk_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!j_vec[b] && !k_vec[b]) |=> $stable(state_q[b]));
    p_jk_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (!j_vec[b] && k_vec[b]) |=> !state_q[b]);
    p_jk_set_r5: assert property (@(posedge clk) disable iff (rst)
      (j_vec[b] && !k_vec[b]) |=> state_q[b]);
    p_jk_toggle_r5: assert property (@(posedge clk) disable iff (rst)
      (j_vec[b] && k_vec[b]) |=> state_q[b] != $past(state_q[b]));
  end

  // R6: a run of 1s parks in two-seen
  p_ones_park_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TWO && din) |=> (state_q == ST_TWO && !hit));

  // R7: the output pulse lasts one period
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

bind seq110_detector seq110_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .hit     (hit),
  .state_q (state_q),
  .j_vec   (j_vec),
  .k_vec   (k_vec)
);

// File: tb/seq110_detector_tb_top.sv
`timescale 1ns/1ps
module seq110_detector_tb_top;
  localparam int PERIOD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;
  logic jj = 1'b0, jk = 1'b0, jq;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] hist = 3'b000;

  always #(PERIOD/2) clk = ~clk;

  seq110_detector dut_i (.clk(clk), .rst(rst), .din(din), .hit(hit));
  seq110_jk_ff    jk_i  (.clk(clk), .rst(rst), .j(jj), .k(jk), .q(jq));

  function automatic logic expect_hit(input logic [2:0] h);
    return h == 3'b110;
  endfunction

  function automatic logic expect_jk(input logic q, input logic j, input logic k);
    if (j && k) return !q;
    if (j)      return 1'b1;
    if (k)      return 1'b0;
    return q;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, clock, then check at the next falling edge.
  task automatic step(input logic a, input string req);
    din = a;
    @(posedge clk);
    hist = {hist[1:0], a};
    @(negedge clk);
    chk(hit, expect_hit(hist), req);
  endtask

  task automatic jk_step(input logic j, input logic k);
    logic e;
    e = expect_jk(jq, j, k);
    jj = j; jk = k;
    @(posedge clk);
    @(negedge clk);
    chk(jq, e, "R5");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hist = 3'b000;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1101));
    repeat (3) @(negedge clk);
    chk(hit, 1'b0, "R1");
    chk(jq, 1'b0, "R1");
    rst = 1'b0;

    // R5: JK element through all codes
    jk_step(1'b1, 1'b0);
    jk_step(1'b0, 1'b0);
    jk_step(1'b1, 1'b1);
    jk_step(1'b1, 1'b1);
    jk_step(1'b0, 1'b1);
    jk_step(1'b0, 1'b1);
    jk_step(1'b0, 1'b0);

    do_reset();
    // R2: plain pattern
    step(1'b1, "R2"); step(1'b1, "R2"); step(1'b0, "R2");
    chk(hit, 1'b1, "R2");
    // R3: change din mid-cycle while the match state is held
    din = ~din; #3; chk(hit, 1'b1, "R3");
    din = ~din; #3; chk(hit, 1'b1, "R3");
    @(negedge clk);
    step(1'b0, "R7");
    chk(hit, 1'b0, "R3");
    din = 1'b1; #3; chk(hit, 1'b0, "R3");
    @(negedge clk);

    // R6: long run of ones then a zero
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, "R6");
    step(1'b0, "R6");
    chk(hit, 1'b1, "R6");

    // R7: overlapping patterns
    do_reset();
    step(1'b1, "R7"); step(1'b1, "R7"); step(1'b0, "R7");
    step(1'b1, "R7"); step(1'b1, "R7"); step(1'b0, "R7");
    chk(hit, 1'b1, "R7");
    step(1'b0, "R7");
    chk(hit, 1'b0, "R7");

    // R1: asynchronous reset between edges
    step(1'b1, "R2"); step(1'b1, "R2"); step(1'b0, "R2");
    #2 rst = 1'b1;
    #1 chk(hit, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
    hist = 3'b000;
    // R1: after release a single zero does not match
    step(1'b0, "R1");

    // R4: random stimulus biased toward ones
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, "R4");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule